// File: doc/BRIEF.md
# Dual-mode serial clock divider

This block derives the serial clock of an SPI master from the module clock. A single configuration word selects one of two division schemes. In linear mode the serial period is an even multiple of the module clock period, set by an 8-bit count. In exponent mode the serial period is a power of two, set by a 4-bit exponent. The block does not compute these settings from a target rate. It applies whatever fields it is given.

Besides the serial clock level, the block gives the shift engine two one-cycle strobes. One marks the cycle in which the serial clock goes high (leading edge). The other marks the cycle in which it goes low (trailing edge). High and low halves always have equal length. The divider runs only while `run` is high and falls silent one cycle after `run` drops. New divider fields are taken only at the start of a half period, so a change never cuts a half short.

The control is a three-state machine:
- `ST_IDLE`: clock low, no strobes.
- `ST_LEAD_HALF`: clock high.
- `ST_TRAIL_HALF`: clock low.

It has four transitions:
- START: `ST_IDLE` to `ST_LEAD_HALF` when `run` is high.
- TO_TRAIL: `ST_LEAD_HALF` to `ST_TRAIL_HALF` when the half-period count expires.
- TO_LEAD: `ST_TRAIL_HALF` to `ST_LEAD_HALF` when the count expires.
- STOP: any active state to `ST_IDLE` when `run` is low.

Top module: `dual_sclk_div`

## Requirements
- R1: While `rst_n` is low, and right after reset, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: Linear mode is selected when `div_cfg[12]` = 1. Each half period then lasts N+1 module clock cycles, where N = `div_cfg[7:0]`. The full period is 2*(N+1) cycles, so the smallest division is 2.
- R3: Exponent mode is selected when `div_cfg[12]` = 0. For M = `div_cfg[11:8]` of 1 or more, each half period lasts 2^(M-1) cycles, giving a period of 2^M.
- R4: In exponent mode, M = 0 requests no division. Since the serial clock may not run faster than half the module clock, M = 0 is served as division by two, with a half period of 1 cycle.
- R5: The high half and the low half of every serial clock period have the same length (50 % duty).
- R6: `lead_stb` is high for exactly the first cycle in which `sclk` is high. `trail_stb` is high for exactly the first cycle in which `sclk` is low after a high half that ran to completion. The two strobes are never high together.
- R7: When `run` is sampled high in the idle state, `sclk` and `lead_stb` are high in the very next cycle.
- R8: One cycle after `run` is sampled low, `sclk` is 0 and neither strobe is high. This holds even in the middle of a half period, and no strobe appears for as long as `run` stays low.
- R9: The divider fields are sampled only when a half period starts. A change in the middle of a half leaves that half's length unchanged and takes effect from the next half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables serial clock generation |
| div_cfg | input | 13 | Divider word: [7:0] linear count N, [11:8] exponent M, [12] mode (1 = linear) |
| sclk | output | 1 | Serial clock level, idle low |
| lead_stb | output | 1 | One-cycle strobe at each leading (rising) edge |
| trail_stb | output | 1 | One-cycle strobe at each trailing (falling) edge |

## Verification
Linear mode is tried with N = 0, 3 and 255. These cover the fastest setting, an ordinary setting and the 8-bit limit, which would expose an off-by-one or a truncated count. Exponent mode is tried with M = 1, 4, 10 and 0. These separate a correct 2^(M-1) half period from a shift that is one position off, and show that the zero exponent falls back to division by two. A change of settings in mid-half shows whether the new value leaks into the running half. Dropping `run` in mid-half tells a prompt return to idle apart from a half that first runs out.

// File: rtl/dual_sclk_div_pkg.sv
package dual_sclk_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LEAD_HALF  = 2'd1,
        ST_TRAIL_HALF = 2'd2
    } sclk_state_e;

    function automatic int unsigned wider_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dual_sclk_halfcalc.sv
// Turns the divider word into the reload value of the half-period counter
// (half-period length minus one, in module clock cycles).
module dual_sclk_halfcalc #(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int HALF_W = 14
) (
    input  logic [LIN_W+EXP_W:0] cfg_i,
    output logic [HALF_W-1:0]    reload_o
);
    localparam int MODE_BIT = LIN_W + EXP_W;

    logic               lin_mode;
    logic [LIN_W-1:0]   lin_n;
    logic [EXP_W-1:0]   exp_m;
    logic [HALF_W-1:0]  one_v;
    logic [HALF_W-1:0]  pow_half;

    assign lin_mode = cfg_i[MODE_BIT];
    assign lin_n    = cfg_i[LIN_W-1:0];
    assign exp_m    = cfg_i[LIN_W+EXP_W-1:LIN_W];
    assign one_v    = HALF_W'(1);

    always_comb begin
        if (exp_m == '0) begin
            // a zero exponent is served as division by two
            pow_half = one_v;
        end else begin
            pow_half = one_v << (exp_m - EXP_W'(1));
        end
    end

    generate
        if (HALF_W > LIN_W) begin : g_lin_pad
            always_comb begin
                reload_o = lin_mode ? {{(HALF_W-LIN_W){1'b0}}, lin_n} : (pow_half - one_v);
            end
        end else begin : g_lin_fit
            always_comb begin
                reload_o = lin_mode ? HALF_W'(lin_n) : (pow_half - one_v);
            end
        end
    endgenerate

endmodule

// File: rtl/dual_sclk_counter.sv
// Down counter for one half period; reloads on request, else counts to zero.
module dual_sclk_counter #(
    parameter int HALF_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [HALF_W-1:0] load_val_i,
    output logic              zero_o
);
    logic [HALF_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - HALF_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dual_sclk_div.sv
module dual_sclk_div #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [LIN_W+EXP_W:0] div_cfg,
    output logic                 sclk,
    output logic                 lead_stb,
    output logic                 trail_stb
);
    import dual_sclk_div_pkg::*;

    localparam int EXP_HALF_W = (1 << EXP_W) - 2;
    localparam int HALF_W     = int'(wider_of(LIN_W, wider_of(EXP_HALF_W, 1)));

    sclk_state_e       state_q, state_d;
    logic [HALF_W-1:0] reload_val;
    logic              half_done;
    logic              cnt_load;
    logic              sclk_q, lead_q, trail_q;

    dual_sclk_halfcalc #(
        .LIN_W  (LIN_W),
        .EXP_W  (EXP_W),
        .HALF_W (HALF_W)
    ) i_halfcalc (
        .cfg_i    (div_cfg),
        .reload_o (reload_val)
    );

    dual_sclk_counter #(
        .HALF_W (HALF_W)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (reload_val),
        .zero_o     (half_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) state_d = ST_LEAD_HALF;           // START
            end
            ST_LEAD_HALF: begin
                if (!run)          state_d = ST_IDLE;      // STOP
                else if (half_done) state_d = ST_TRAIL_HALF; // TO_TRAIL
            end
            ST_TRAIL_HALF: begin
                if (!run)          state_d = ST_IDLE;      // STOP
                else if (half_done) state_d = ST_LEAD_HALF;  // TO_LEAD
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // a new half begins whenever an active state is entered afresh
    assign cnt_load = (state_d != ST_IDLE) && (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            sclk_q  <= (state_d == ST_LEAD_HALF);
            lead_q  <= (state_d == ST_LEAD_HALF) && (state_q != ST_LEAD_HALF);
            trail_q <= (state_d == ST_TRAIL_HALF) && (state_q == ST_LEAD_HALF);
        end
    end

    assign sclk      = sclk_q;
    assign lead_stb  = lead_q;
    assign trail_stb = trail_q;

endmodule

// File: rtl/dual_sclk_div_chk.sv
module dual_sclk_div_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!sclk && !lead_stb && !trail_stb)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lead_stb && trail_stb)); // R6
    AST_LEAD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) lead_stb |-> (sclk && !$past(sclk))); // R6
    AST_TRAIL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) trail_stb |-> (!sclk && $past(sclk))); // R6
    AST_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> lead_stb); // R6
    AST_FALL_MARKED: assert property (@(posedge clk) disable iff (!rst_n) ($fell(sclk) && $past(run)) |-> trail_stb); // R6
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (!sclk && !lead_stb && !trail_stb)); // R8
endmodule

bind dual_sclk_div dual_sclk_div_chk i_dual_sclk_div_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/test_dual_sclk_div.sv
module test_dual_sclk_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [12:0] div_cfg = '0;
    logic        sclk, lead_stb, trail_stb;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dual_sclk_div i_dual_sclk_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .div_cfg   (div_cfg),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic logic [12:0] lin_cfg(input int n);
        return {1'b1, 4'd0, 8'(n)};
    endfunction

    function automatic logic [12:0] exp_cfg(input int m);
        return {1'b0, 4'(m), 8'd0};
    endfunction

    task automatic go_idle();
        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // count negedges until a strobe shows; 0 argument = trailing
    task automatic count_to(input bit want_lead, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!(want_lead ? lead_stb : trail_stb) && k < 70000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({sclk, lead_stb, trail_stb} == 3'b000, "R1 in reset", {sclk, lead_stb, trail_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sclk, lead_stb, trail_stb} == 3'b000, "R1 after reset", {sclk, lead_stb, trail_stb}, 0);
    endtask

    task automatic t_idle();
        int seen = 0;
        go_idle();
        div_cfg = lin_cfg(0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sclk || lead_stb || trail_stb) seen++;
        end
        chk(seen == 0, "R8 idle quiet", seen, 0);
    endtask

    task automatic t_period(input logic [12:0] cfg, input int half, input string req);
        int k_hi, k_lo;
        go_idle();
        div_cfg = cfg;
        run = 1'b1;
        @(negedge clk);
        chk(lead_stb && sclk, "R7 start", {lead_stb, sclk}, 3);
        count_to(1'b0, k_hi);
        chk(k_hi == half, {req, " high half"}, k_hi, half);
        chk(!sclk && !lead_stb, "R6 trail edge", {sclk, lead_stb}, 0);
        count_to(1'b1, k_lo);
        chk(k_lo == half, {req, " low half"}, k_lo, half);
        chk(k_lo == k_hi, "R5 duty", k_lo, k_hi);
        chk(sclk && !trail_stb, "R6 lead edge", {sclk, trail_stb}, 2);
    endtask

    task automatic t_midchange();
        int k_hi, k_lo;
        go_idle();
        div_cfg = lin_cfg(7);
        run = 1'b1;
        @(negedge clk);
        repeat (2) @(negedge clk);
        div_cfg = lin_cfg(1);
        count_to(1'b0, k_hi);
        chk(k_hi == 6, "R9 running half kept", k_hi + 2, 8);
        count_to(1'b1, k_lo);
        chk(k_lo == 2, "R9 next half new", k_lo, 2);
    endtask

    task automatic t_stop();
        int seen = 0;
        go_idle();
        div_cfg = lin_cfg(9);
        run = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1, "R2 mid high", sclk, 1);
        run = 1'b0;
        @(negedge clk);
        chk({sclk, lead_stb, trail_stb} == 3'b000, "R8 stop", {sclk, lead_stb, trail_stb}, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sclk || lead_stb || trail_stb) seen++;
        end
        chk(seen == 0, "R8 stays quiet", seen, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_period(lin_cfg(0),   1,   "R2 N=0");
        t_period(lin_cfg(3),   4,   "R2 N=3");
        t_period(lin_cfg(255), 256, "R2 N=255");
        t_period(exp_cfg(1),   1,   "R3 M=1");
        t_period(exp_cfg(4),   8,   "R3 M=4");
        t_period(exp_cfg(10),  512, "R3 M=10");
        t_period(exp_cfg(0),   1,   "R4 M=0");
        t_midchange();
        t_stop();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule